// File: doc/BRIEF.md
# Programmable Serial Clock Period Generator

This block produces the serial clock of a two-wire bus controller. It works on the reference clock and drives an open-drain clock line: its output is an enable that pulls the line low. The actual level of the line comes back on a separate input. Two pairs of period counts are held in registers, one pair for standard speed and one pair for fast speed. A speed field in a control register picks which pair is used.

While the enable input is high, the block makes a continuous clock. Each low phase begins at the moment the block starts pulling the line down, and it lasts a fixed number of cycles set by the programmed low count. After that the block lets go of the line. The high phase is timed only on cycles in which the line is actually seen high. A target device that holds the line low therefore stretches the period and does not shorten the high time.

Registers are written through a simple write port. The period counts and the speed field are frozen while the generator is enabled. START/STOP sequencing and data shifting are handled elsewhere.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, scl_pull_low is 0, the speed field selects fast speed, and the counts hold their parameter reset values.
- R2: While enable is 0, scl_pull_low is 0 from the cycle after enable is sampled low.
- R3: When enable is sampled 1 while the generator is idle, scl_pull_low becomes 1 on the next cycle and a low phase begins.
- R4: A low phase keeps scl_pull_low at 1 for exactly the active low count plus 1 reference cycles.
- R5: When the line follows the release at once, scl_pull_low stays 0 for exactly the active high count plus 8 reference cycles. The next low phase then starts.
- R6: The high-phase count advances only on cycles in which scl_line is 1. If a target holds the line low for k released cycles, the released time is k plus the high count plus 8.
- R7: The speed field is bits [2:1] of the control register at address 0x00. The value 2'b10 (data 0x4) selects the fast counts. Any other value, including 2'b01 (data 0x2), selects the standard counts.
- R8: The standard high count is at address 0x14 and the standard low count is at 0x18. The fast high count is at 0x1C and the fast low count is at 0x20. Each takes the low CNT_W bits of wr_data.
- R9: A register write made while enable is 1 is ignored, so the period afterwards uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| enable | input | 1 | Runs the generator when 1 |
| scl_line | input | 1 | Sensed level of the clock line |
| scl_pull_low | output | 1 | 1 pulls the clock line low |

## Verification
The assertions assume that scl_line is 0 whenever scl_pull_low is 1. This holds for a wired-AND line and is the only case the stretch check relies on. The assertions also assume that enable changes only when the reference clock is stable. The bench models the line as the release minus a hold window that is driven from the negative edge. That window covers only the released phase, so the line never reads high while the block is pulling it low. The bench changes enable and register writes only on negative edges.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 8,
  parameter logic [CNT_W-1:0] RST_SS_HIGH = 16'd32,
  parameter logic [CNT_W-1:0] RST_SS_LOW  = 16'd40,
  parameter logic [CNT_W-1:0] RST_FS_HIGH = 16'd4,
  parameter logic [CNT_W-1:0] RST_FS_LOW  = 16'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              enable,
  input  logic              scl_line,
  output logic              scl_pull_low
);
  localparam int CW = CNT_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SSH  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_SSL  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_FSH  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_FSL  = ADDR_W'(8'h20);
  localparam logic [CW-1:0] HIGH_EXTRA = CW'(7);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_REL} st_t;

  st_t st;
  logic [CNT_W-1:0] ss_h, ss_l, fs_h, fs_l;
  logic [1:0] speed;
  logic [CW-1:0] cnt;

  wire cfg_we   = wr_en && !enable;
  wire use_fast = (speed == 2'b10);
  wire [CNT_W-1:0] cur_h = use_fast ? fs_h : ss_h;
  wire [CNT_W-1:0] cur_l = use_fast ? fs_l : ss_l;
  wire [CW-1:0] lo_last = {1'b0, cur_l};
  wire [CW-1:0] hi_last = {1'b0, cur_h} + HIGH_EXTRA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_h  <= RST_SS_HIGH;
      ss_l  <= RST_SS_LOW;
      fs_h  <= RST_FS_HIGH;
      fs_l  <= RST_FS_LOW;
      speed <= 2'b10;
    end else if (cfg_we) begin
      case (wr_addr)
        A_CTRL:  speed <= wr_data[2:1];
        A_SSH:   ss_h  <= wr_data;
        A_SSL:   ss_l  <= wr_data;
        A_FSH:   fs_h  <= wr_data;
        A_FSL:   fs_l  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!enable) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          st  <= ST_LOW;
          cnt <= '0;
        end
        ST_LOW: begin
          if (cnt == lo_last) begin
            st  <= ST_REL;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (scl_line) begin
            if (cnt == hi_last) begin
              st  <= ST_LOW;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign scl_pull_low = (st == ST_LOW);

  AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_pull_low); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && enable) |=> scl_pull_low); // R3

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> cnt <= lo_last); // R4

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REL && enable && !scl_line) |=> (!scl_pull_low && $stable(cnt))); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> ($stable(ss_h) && $stable(ss_l) && $stable(fs_h)
                       && $stable(fs_l) && $stable(speed))); // R9
endmodule

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic enable = 1'b0;
  logic hold = 1'b0;
  logic scl_pull_low;
  wire  scl_line = !scl_pull_low && !hold;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scl_period_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .enable(enable), .scl_line(scl_line),
    .scl_pull_low(scl_pull_low));

  // ctrl, ss_high, ss_low, fs_high, fs_low, stretch
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{4, 5, 6, 2, 3, 0},
    '{2, 5, 6, 2, 3, 0},
    '{2, 0, 0, 7, 7, 3},
    '{4, 3, 3, 9, 1, 5},
    '{6, 1, 2, 8, 8, 2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int stretch, output int lo, output int hi);
    int rem;
    lo = 0; hi = 0; rem = stretch;
    while (scl_pull_low && lo < 100000) begin
      lo++;
      @(negedge clk);
    end
    while (!scl_pull_low && hi < 100000) begin
      hold = (rem > 0);
      if (rem > 0) rem--;
      hi++;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic run_period(input int stretch, output int lo, output int hi);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R3 low starts after enable", int'(scl_pull_low), 1);
    measure(stretch, lo, hi);
  endtask

  task automatic stop_gen();
    enable = 1'b0;
    @(negedge clk);
    check("R2 released when disabled", int'(scl_pull_low), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi, el, eh, lo2, hi2;
    repeat (3) @(negedge clk);
    check("R1 reset release", int'(scl_pull_low), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(scl_pull_low), 0);

    // R1: reset defaults: fast selected, fast high 4, fast low 10
    run_period(0, lo, hi);
    check("R1 default low", lo, 11);
    check("R1 default high", hi, 12);
    stop_gen();

    for (int v = 0; v < NV; v++) begin
      wr(8'h00, VEC[v][0]);
      wr(8'h14, VEC[v][1]);
      wr(8'h18, VEC[v][2]);
      wr(8'h1C, VEC[v][3]);
      wr(8'h20, VEC[v][4]);
      if (((VEC[v][0] >> 1) & 3) == 2) begin
        el = VEC[v][4] + 1; eh = VEC[v][3] + 8;
      end else begin
        el = VEC[v][2] + 1; eh = VEC[v][1] + 8;
      end
      run_period(VEC[v][5], lo, hi);
      check("R4 R7 R8 low length", lo, el);
      check("R5 R6 R7 R8 high length", hi, eh + VEC[v][5]);
      measure(0, lo2, hi2);
      check("R4 second low length", lo2, el);
      check("R5 second high length", hi2, eh);
      stop_gen();
    end

    // R9: writes while enabled are ignored
    wr(8'h00, 2);
    wr(8'h14, 4);
    wr(8'h18, 2);
    @(negedge clk);
    enable = 1'b1;
    wr(8'h14, 20);
    wr(8'h18, 30);
    wr(8'h00, 4);
    stop_gen();
    run_period(0, lo, hi);
    check("R9 low count unchanged", lo, 3);
    check("R9 high count unchanged", hi, 12);
    stop_gen();

    // R6: long stretch at minimum counts
    wr(8'h14, 0);
    wr(8'h18, 0);
    run_period(40, lo, hi);
    check("R6 long stretch low", lo, 1);
    check("R6 long stretch high", hi, 48);
    stop_gen();

    // R2: disable mid low phase
    wr(8'h18, 50);
    @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 still low mid phase", int'(scl_pull_low), 1);
    stop_gen();
    repeat (3) @(negedge clk);
    check("R2 stays released", int'(scl_pull_low), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule